// File: doc/BRIEF.md
# Digital Automatic Gain Controller

This block closes the digital side of a read channel's level loop. Two comparator flags from an external level detector say whether the channel output is too small or too large. The block turns them into a gain code, in 1 dB steps, for a variable gain stage. The code rises slowly while the signal is weak and falls about fifty times faster while it is strong. Each step happens only after the request has persisted for a programmable number of clock cycles.

The loop can be paused in two ways: with an active-low hold input or while the channel is writing. A servo select makes the output show the highest permitted code for as long as it is high. It leaves the stored gain untouched, so the loop resumes where it stopped. A fixed-gain select bypasses the loop and passes a register-supplied code through instead. An extend bit widens the upper limit of the range. A direction bit reports which way the loop was last asked to move, for use by software that runs its own gain algorithm.

Top module: `agc_gain_ctrl`

## Requirements
- R1: After reset, gainCode is 0 and dirDown is 0.
- R2: The upper limit is BASE_MAX (15) with extendRange low and BASE_MAX+EXT_ADD (21) with it high. gainCode never exceeds the current limit. Stepping saturates at 0 and at the limit and never wraps.
- R3: While the loop runs and only tooSmall is high, the gain rises by one code per UP_CYCLES cycles. The first step lands on the UP_CYCLES+1-th rising edge after the request first appears. The gain never moves by more than one code per cycle.
- R4: While the loop runs and tooLarge is high, the gain falls by one code per DOWN_CYCLES cycles, timed the same way. tooLarge takes priority over tooSmall when both are high.
- R5: The step timer restarts whenever the effective request changes, including to or from no request and into or out of a pause.
- R6: While holdN is low or writing is high, the stored gain and dirDown do not change.
- R7: While servoSel is high, gainCode equals the current upper limit and the stored gain is kept. Once servoSel drops, the stored gain (clamped to the limit) is output again.
- R8: While fixedSel is high (and servoSel low), gainCode equals regGain clamped to the upper limit, and the loop is paused.
- R9: dirDown is 1 after a decrease request is seen while the loop runs and 0 after an increase request. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tooSmall | input | 1 | Level detector: output below target |
| tooLarge | input | 1 | Level detector: output above target |
| holdN | input | 1 | Pause the loop while low |
| writing | input | 1 | Channel is writing; pauses the loop |
| servoSel | input | 1 | Force maximum gain without altering stored gain |
| fixedSel | input | 1 | Use regGain instead of the loop |
| regGain | input | 5 | Register-supplied gain code |
| extendRange | input | 1 | Raise upper limit by EXT_ADD codes |
| gainCode | output | 5 | Gain code to the variable gain stage (1 dB per code) |
| dirDown | output | 1 | Last requested direction: 1 down, 0 up |

## Verification
The step and freeze properties compare gainCode with its value one cycle earlier. They apply only when the output source (loop, servo or fixed) and extendRange were the same in both cycles, because a change of source or limit may legitimately move the code by more than one step. The stimulus changes mode and extend inputs only on the falling clock edge, one at a time per table row, so those properties are always either inactive or evaluated within one steady mode. The bench shortens the step periods through parameters, so that full ramps fit in a short run without changing how the timing is counted.

// File: rtl/agc_pkg.sv
package agc_pkg;
  // Effective adjustment request seen by the step timer
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_UP   = 2'd1,
    REQ_DOWN = 2'd2
  } agcReq_e;

  // Strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepCmd_t;
endpackage

// File: rtl/agc_ctrl.sv
module agc_ctrl
  import agc_pkg::*;
#(
  parameter int UP_CYCLES   = 16000,
  parameter int DOWN_CYCLES = 320
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tooSmall,
  input  logic     tooLarge,
  input  logic     holdN,
  input  logic     writing,
  input  logic     servoSel,
  input  logic     fixedSel,
  output stepCmd_t cmd,
  output logic     dirDown
);
  localparam int LONGEST = (UP_CYCLES > DOWN_CYCLES) ? UP_CYCLES : DOWN_CYCLES;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] UP_LAST   = CNT_W'(UP_CYCLES - 1);
  localparam logic [CNT_W-1:0] DOWN_LAST = CNT_W'(DOWN_CYCLES - 1);

  logic             loopRun;
  agcReq_e          reqNow;
  agcReq_e          reqPrev;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] tickLast;
  logic             sameReq;
  logic             stepHit;

  always_comb begin
    loopRun = holdN && !writing && !servoSel && !fixedSel;
    if (!loopRun)      reqNow = REQ_NONE;
    else if (tooLarge) reqNow = REQ_DOWN;   // decrease wins
    else if (tooSmall) reqNow = REQ_UP;
    else               reqNow = REQ_NONE;
    tickLast = (reqNow == REQ_DOWN) ? DOWN_LAST : UP_LAST;
    sameReq  = (reqNow != REQ_NONE) && (reqNow == reqPrev);
    stepHit  = sameReq && (tickCnt == tickLast);
    cmd.stepUp   = stepHit && (reqNow == REQ_UP);
    cmd.stepDown = stepHit && (reqNow == REQ_DOWN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev <= REQ_NONE;
      tickCnt <= '0;
      dirDown <= 1'b0;
    end else begin
      reqPrev <= reqNow;
      if (!sameReq || stepHit) tickCnt <= '0;
      else                     tickCnt <= tickCnt + 1'b1;
      if (reqNow != REQ_NONE)  dirDown <= (reqNow == REQ_DOWN);
    end
  end
endmodule

// File: rtl/agc_gain_dp.sv
module agc_gain_dp
  import agc_pkg::*;
#(
  parameter int GAIN_W   = 5,
  parameter int BASE_MAX = 15,
  parameter int EXT_ADD  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCmd_t          cmd,
  input  logic              servoSel,
  input  logic              fixedSel,
  input  logic              extendRange,
  input  logic [GAIN_W-1:0] regGain,
  output logic [GAIN_W-1:0] gainCode
);
  localparam logic [GAIN_W-1:0] LIM_BASE = GAIN_W'(BASE_MAX);
  localparam logic [GAIN_W-1:0] LIM_EXT  = GAIN_W'(BASE_MAX + EXT_ADD);

  logic [GAIN_W-1:0] storedGain;
  logic [GAIN_W-1:0] limitGain;
  logic [GAIN_W-1:0] effGain;
  logic [GAIN_W-1:0] fixedGain;

  always_comb begin
    limitGain = extendRange ? LIM_EXT : LIM_BASE;
    effGain   = (storedGain > limitGain) ? limitGain : storedGain;
    fixedGain = (regGain > limitGain) ? limitGain : regGain;
    if (servoSel)      gainCode = limitGain;
    else if (fixedSel) gainCode = fixedGain;
    else               gainCode = effGain;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storedGain <= '0;
    end else if (cmd.stepDown) begin
      if (effGain != '0) storedGain <= effGain - 1'b1;
      else               storedGain <= '0;
    end else if (cmd.stepUp) begin
      if (effGain != limitGain) storedGain <= effGain + 1'b1;
      else                      storedGain <= limitGain;
    end
  end
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
  import agc_pkg::*;
#(
  parameter int GAIN_W      = 5,
  parameter int BASE_MAX    = 15,
  parameter int EXT_ADD     = 6,
  parameter int UP_CYCLES   = 16000,
  parameter int DOWN_CYCLES = 320
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tooSmall,
  input  logic              tooLarge,
  input  logic              holdN,
  input  logic              writing,
  input  logic              servoSel,
  input  logic              fixedSel,
  input  logic [GAIN_W-1:0] regGain,
  input  logic              extendRange,
  output logic [GAIN_W-1:0] gainCode,
  output logic              dirDown
);
  stepCmd_t stepCmd;

  agc_ctrl #(
    .UP_CYCLES  (UP_CYCLES),
    .DOWN_CYCLES(DOWN_CYCLES)
  ) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tooSmall(tooSmall),
    .tooLarge(tooLarge),
    .holdN   (holdN),
    .writing (writing),
    .servoSel(servoSel),
    .fixedSel(fixedSel),
    .cmd     (stepCmd),
    .dirDown (dirDown)
  );

  agc_gain_dp #(
    .GAIN_W  (GAIN_W),
    .BASE_MAX(BASE_MAX),
    .EXT_ADD (EXT_ADD)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (stepCmd),
    .servoSel   (servoSel),
    .fixedSel   (fixedSel),
    .extendRange(extendRange),
    .regGain    (regGain),
    .gainCode   (gainCode)
  );
endmodule

// File: rtl/agc_gain_ctrl_checker.sv
module agc_gain_ctrl_checker #(
  parameter int GAIN_W   = 5,
  parameter int BASE_MAX = 15,
  parameter int EXT_ADD  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              tooSmall,
  input logic              tooLarge,
  input logic              holdN,
  input logic              writing,
  input logic              servoSel,
  input logic              fixedSel,
  input logic [GAIN_W-1:0] regGain,
  input logic              extendRange,
  input logic [GAIN_W-1:0] gainCode,
  input logic              dirDown
);
  logic [GAIN_W:0] maxG;
  logic [GAIN_W:0] gainX;
  logic [GAIN_W:0] regX;
  logic            loopOut;
  logic            loopRun;

  assign maxG    = extendRange ? (GAIN_W+1)'(BASE_MAX + EXT_ADD) : (GAIN_W+1)'(BASE_MAX);
  assign gainX   = {1'b0, gainCode};
  assign regX    = {1'b0, regGain};
  assign loopOut = !servoSel && !fixedSel;
  assign loopRun = loopOut && holdN && !writing;

  assert_gain_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    gainX <= maxG);

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && loopOut && $past(loopOut) && $stable(extendRange)
    |-> (gainX <= $past(gainX) + 1'b1) && ($past(gainX) <= gainX + 1'b1));

  assert_down_priority_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(tooLarge && loopRun) && loopOut && $past(loopOut)
    && $stable(extendRange) |-> gainX <= $past(gainX));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(loopOut && (!holdN || writing)) && loopOut
    && $stable(extendRange) |-> $stable(gainCode));

  assert_servo_max_R7: assert property (@(posedge clk) disable iff (!rstN)
    servoSel |-> gainX == maxG);

  assert_fixed_gain_R8: assert property (@(posedge clk) disable iff (!rstN)
    fixedSel && !servoSel |-> gainX == ((regX > maxG) ? maxG : regX));

  assert_dir_down_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(tooLarge && loopRun) |-> dirDown);

  assert_dir_up_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(tooSmall && !tooLarge && loopRun) |-> !dirDown);
endmodule

bind agc_gain_ctrl agc_gain_ctrl_checker #(
  .GAIN_W  (GAIN_W),
  .BASE_MAX(BASE_MAX),
  .EXT_ADD (EXT_ADD)
) chk (
  .clk        (clk),
  .rstN       (rstN),
  .tooSmall   (tooSmall),
  .tooLarge   (tooLarge),
  .holdN      (holdN),
  .writing    (writing),
  .servoSel   (servoSel),
  .fixedSel   (fixedSel),
  .regGain    (regGain),
  .extendRange(extendRange),
  .gainCode   (gainCode),
  .dirDown    (dirDown)
);

// File: tb/agc_gain_ctrl_test.sv
module agc_gain_ctrl_test;
  localparam int UPC = 6;
  localparam int DNC = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tooSmall = 1'b0, tooLarge = 1'b0, holdN = 1'b1, writing = 1'b0;
  logic       servoSel = 1'b0, fixedSel = 1'b0, extendRange = 1'b0;
  logic [4:0] regGain = 5'd0;
  logic [4:0] gainCode;
  logic       dirDown;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  agc_gain_ctrl #(.GAIN_W(5), .BASE_MAX(15), .EXT_ADD(6),
                  .UP_CYCLES(UPC), .DOWN_CYCLES(DNC)) uut (
    .clk(clk), .rstN(rstN), .tooSmall(tooSmall), .tooLarge(tooLarge),
    .holdN(holdN), .writing(writing), .servoSel(servoSel), .fixedSel(fixedSel),
    .regGain(regGain), .extendRange(extendRange),
    .gainCode(gainCode), .dirDown(dirDown));

  typedef struct packed {
    logic       hN, wr, sv, fx, sm, lg, ex;
    logic [4:0] rg;
    logic [7:0] n;
    logic [4:0] expG;
    logic       expD;
    logic [3:0] req;
  } vec_t;

  // Rows alternate request or mode so each starts a fresh step timer
  localparam vec_t VECS [16] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,5'd0, 8'd13,5'd2, 1'b0,4'd3},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,5'd0, 8'd3, 5'd1, 1'b1,4'd4},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,5'd0, 8'd61,5'd11,1'b0,4'd3},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0, 8'd5, 5'd11,1'b0,4'd9},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,5'd0, 8'd61,5'd15,1'b0,4'd2},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,5'd0, 8'd10,5'd15,1'b0,4'd6},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,5'd0, 8'd37,5'd21,1'b0,4'd2},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,5'd0, 8'd5, 5'd15,1'b0,4'd7},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,5'd0, 8'd3, 5'd21,1'b0,4'd7},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,5'd7, 8'd5, 5'd7, 1'b0,4'd8},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,5'd0, 8'd9, 5'd21,1'b0,4'd6},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,5'd0, 8'd9, 5'd17,1'b1,4'd4},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,5'd0, 8'd2, 5'd17,1'b1,4'd9},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,5'd0, 8'd41,5'd0, 1'b1,4'd2},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,5'd0, 8'd7, 5'd1, 1'b0,4'd3},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,5'd20,8'd2, 5'd15,1'b0,4'd8}
  };

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOut(input string tag, input logic [4:0] eg, input logic ed);
    checks++;
    if (gainCode !== eg) begin
      fails++;
      $display("FAIL %s gainCode actual %0d expected %0d", tag, gainCode, eg);
    end
    checks++;
    if (dirDown !== ed) begin
      fails++;
      $display("FAIL %s dirDown actual %0d expected %0d", tag, dirDown, ed);
    end
  endtask

  task automatic setIn(input vec_t v);
    holdN = v.hN; writing = v.wr; servoSel = v.sv; fixedSel = v.fx;
    tooSmall = v.sm; tooLarge = v.lg; extendRange = v.ex; regGain = v.rg;
  endtask

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    run(3);
    checkOut("R1 reset", 5'd0, 1'b0);
    rstN = 1'b1;
    run(2);
    checkOut("R1 after release", 5'd0, 1'b0);

    for (int i = 0; i < 16; i++) begin
      setIn(VECS[i]);
      run(int'(VECS[i].n));
      checkOut(reqName(VECS[i].req), VECS[i].expG, VECS[i].expD);
    end

    // R5: direction change restarts the timer (state: gain 1, up)
    fixedSel = 1'b0; regGain = 5'd0;
    run(1);
    tooSmall = 1'b1;
    run(4);
    checkOut("R5 partial up", 5'd1, 1'b0);
    tooSmall = 1'b0; tooLarge = 1'b1;
    run(2);
    checkOut("R5 down restarted", 5'd1, 1'b1);
    run(1);
    checkOut("R5 down step", 5'd0, 1'b1);
    tooLarge = 1'b0;
    run(1);
    // R3: exact first-step edge
    tooSmall = 1'b1;
    run(UPC);
    checkOut("R3 before first step", 5'd0, 1'b0);
    run(1);
    checkOut("R3 first step", 5'd1, 1'b0);
    run(UPC);
    checkOut("R3 second step", 5'd2, 1'b0);
    // R1: reset mid-operation
    rstN = 1'b0;
    run(1);
    checkOut("R1 mid reset", 5'd0, 1'b0);
    tooSmall = 1'b0;
    rstN = 1'b1;
    run(2);
    checkOut("R1 idle after reset", 5'd0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule